// File: doc/BRIEF.md
# Frame Alignment Defect Monitor

This block turns per-frame framing check results from an STS-3 receiver into the severely-errored-frame (SEF) and loss-of-frame (LOF) defect indications. An upstream framer supplies a strobe once per frame period, together with a flag that says whether that frame's alignment bytes matched. A three-state machine tracks whether the stream is severely errored, provisionally aligned, or fully in frame. The machine's state is the pair of defect flags.

Each change of SEF or LOF, and each change of the externally supplied LOS bit, sets a sticky bit in an interrupt byte. Reading that byte clears it. An active-low interrupt output stays low while any enabled pending bit is set. A one-bit address selects either the defect status byte or the interrupt byte on a combinational read port. The number of clean frames needed to leave the provisional state can be programmed.

Top module: `fa_defect_monitor`

## Requirements
- R1: After reset the block is in the severely errored state (SEF=1, LOF=1), the interrupt byte is 0 and `int_n` is 1.
- R2: In the SEF=1/LOF=1 state, two consecutive good frames move the machine to SEF=0/LOF=1 and set interrupt bit 1. A bad frame restarts that count.
- R3: In the SEF=0/LOF=1 state, a run of good frames equal to `frame_thr` clears LOF, which moves the machine to in-frame and sets interrupt bit 2.
- R4: A bad frame in the SEF=0/LOF=1 state restarts the good-frame run. The machine stays out of frame.
- R5: Four consecutive bad frames in the SEF=0/LOF=1 state set SEF (state SEF=1/LOF=1) and set interrupt bit 1.
- R6: In the in-frame state, four consecutive bad frames return the machine to SEF=1/LOF=1 and set interrupt bits 1 and 2. A good frame restarts that count.
- R7: A `frame_thr` value of 0 behaves like 1.
- R8: Reading address 0 returns the status byte: bit0 LOS, bit1 SEF, bit2 LOF, bits 7..3 zero. The read has no side effect.
- R9: Reading address 1 returns the interrupt byte: bit0 LOS changed, bit1 SEF changed, bit2 LOF changed, bits 7..3 zero. The byte clears on the clock edge that ends the read.
- R10: An event that occurs on the same edge as an interrupt-byte read remains set after the read.
- R11: `int_n` is 0 exactly when some interrupt bit is set while its `int_mask` bit is 1.
- R12: Cycles without `frame_strobe` leave the defect state unchanged, whatever `frame_ok` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | One cycle per received frame |
| frame_ok | input | 1 | Alignment bytes of this frame matched (valid with strobe) |
| los_in | input | 1 | Loss-of-signal indication from elsewhere |
| frame_thr | input | 4 | Good frames needed to clear LOF |
| int_mask | input | 8 | Per-bit interrupt enable |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | 0 = status byte, 1 = interrupt byte |
| rd_data | output | 8 | Read data, combinational |
| sef | output | 1 | SEF defect |
| lof | output | 1 | LOF defect |
| int_n | output | 1 | Active-low interrupt |

## Verification
The embedded assertions check the following on every cycle:
- SEF is never set while LOF is clear.
- The state never moves without a frame strobe.
- LOF clears only on a good frame, and SEF is set only on a bad frame.
- Every state change leaves its interrupt bit set.
- An event that coincides with a read survives that read.

Only the bench scenarios can show that the run lengths are exact: two, the programmed threshold (including 0), and four. They also show that interrupted runs restart, that the mask gates the interrupt pin, and that the byte clears after a read.

// File: rtl/fa_defect_pkg.sv
package fa_defect_pkg;
    typedef enum logic [1:0] {
        ST_SEF = 2'd0,
        ST_PRE = 2'd1,
        ST_INF = 2'd2
    } fa_state_e;

    localparam int BIT_LOS = 0;
    localparam int BIT_SEF = 1;
    localparam int BIT_LOF = 2;
    localparam int EV_W    = 3;
endpackage

// File: rtl/fa_align_fsm.sv
module fa_align_fsm
    import fa_defect_pkg::*;
#(
    parameter int THR_W      = 4,
    parameter int EXIT_GOOD  = 2,
    parameter int BAD_LIMIT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_strobe,
    input  logic             frame_ok,
    input  logic             los_in,
    input  logic [THR_W-1:0] frame_thr,
    output logic             sef,
    output logic             lof,
    output logic             los_q,
    output logic [EV_W-1:0]  ev
);
    localparam int BAD_W = $clog2(BAD_LIMIT + 1);

    typedef struct packed {
        fa_state_e        st;
        logic [THR_W-1:0] good;
        logic [BAD_W-1:0] bad;
        logic             los;
    } fsm_t;

    fsm_t r_q, r_d;
    logic [EV_W-1:0] ev_d;
    logic [THR_W:0]  good_inc;
    logic [THR_W:0]  thr_eff;
    logic [BAD_W:0]  bad_inc;

    always_comb begin
        r_d      = r_q;
        ev_d     = '0;
        good_inc = {1'b0, r_q.good} + 1'b1;
        bad_inc  = {1'b0, r_q.bad} + 1'b1;
        thr_eff  = (frame_thr == '0) ? {{THR_W{1'b0}}, 1'b1} : {1'b0, frame_thr};

        if (los_in != r_q.los) begin
            r_d.los       = los_in;
            ev_d[BIT_LOS] = 1'b1;
        end

        if (frame_strobe) begin
            unique case (r_q.st)
                ST_SEF: begin
                    if (frame_ok) begin
                        if (good_inc >= (THR_W+1)'(EXIT_GOOD)) begin
                            r_d.st        = ST_PRE;
                            r_d.good      = '0;
                            r_d.bad       = '0;
                            ev_d[BIT_SEF] = 1'b1;
                        end else begin
                            r_d.good = good_inc[THR_W-1:0];
                        end
                    end else begin
                        r_d.good = '0;
                    end
                end
                ST_PRE: begin
                    if (frame_ok) begin
                        r_d.bad = '0;
                        if (good_inc >= thr_eff) begin
                            r_d.st        = ST_INF;
                            r_d.good      = '0;
                            ev_d[BIT_LOF] = 1'b1;
                        end else begin
                            r_d.good = good_inc[THR_W-1:0];
                        end
                    end else begin
                        r_d.good = '0;
                        if (bad_inc >= (BAD_W+1)'(BAD_LIMIT)) begin
                            r_d.st        = ST_SEF;
                            r_d.bad       = '0;
                            ev_d[BIT_SEF] = 1'b1;
                        end else begin
                            r_d.bad = bad_inc[BAD_W-1:0];
                        end
                    end
                end
                default: begin
                    if (frame_ok) begin
                        r_d.bad = '0;
                    end else if (bad_inc >= (BAD_W+1)'(BAD_LIMIT)) begin
                        r_d.st        = ST_SEF;
                        r_d.bad       = '0;
                        r_d.good      = '0;
                        ev_d[BIT_SEF] = 1'b1;
                        ev_d[BIT_LOF] = 1'b1;
                    end else begin
                        r_d.bad = bad_inc[BAD_W-1:0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_SEF, good: '0, bad: '0, los: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sef   = (r_q.st == ST_SEF);
    assign lof   = (r_q.st != ST_INF);
    assign los_q = r_q.los;
    assign ev    = ev_d;

    // R1: SEF never appears without LOF
    a_r1_sef_implies_lof: assert property (@(posedge clk) disable iff (!rst_n)
        sef |-> lof);
    // R12: no strobe, no state movement
    a_r12_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(r_q.st));
    // R3: LOF clears only on a good frame
    a_r3_lof_clear_on_good: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lof) |-> $past(frame_strobe && frame_ok));
    // R5 / R6: SEF is declared only on a bad frame
    a_r5_sef_set_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sef) |-> $past(frame_strobe && !frame_ok));
endmodule

// File: rtl/fa_irq_regs.sv
module fa_irq_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         rd_clr,
    output logic [W-1:0] irq
);
    typedef struct packed {
        logic [W-1:0] pend;
    } irq_t;

    irq_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.pend = (rd_clr ? '0 : s_q.pend) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = s_q.pend;

    // R10: an event is never lost, even under a clearing read
    a_r10_event_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((irq & $past(ev)) == $past(ev)));
    // R9: a read with no new event leaves the byte empty
    a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ev == '0) |=> (irq == '0));
endmodule

// File: rtl/fa_defect_monitor.sv
module fa_defect_monitor
    import fa_defect_pkg::*;
#(
    parameter int THR_W     = 4,
    parameter int EXIT_GOOD = 2,
    parameter int BAD_LIMIT = 4,
    parameter int REG_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_strobe,
    input  logic             frame_ok,
    input  logic             los_in,
    input  logic [THR_W-1:0] frame_thr,
    input  logic [REG_W-1:0] int_mask,
    input  logic             rd_en,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             sef,
    output logic             lof,
    output logic             int_n
);
    logic [EV_W-1:0]  ev3;
    logic [REG_W-1:0] ev_full;
    logic [REG_W-1:0] irq;
    logic [REG_W-1:0] status;
    logic             los_q;

    fa_align_fsm #(
        .THR_W    (THR_W),
        .EXIT_GOOD(EXIT_GOOD),
        .BAD_LIMIT(BAD_LIMIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_strobe(frame_strobe),
        .frame_ok    (frame_ok),
        .los_in      (los_in),
        .frame_thr   (frame_thr),
        .sef         (sef),
        .lof         (lof),
        .los_q       (los_q),
        .ev          (ev3)
    );

    assign ev_full = {{(REG_W-EV_W){1'b0}}, ev3};

    fa_irq_regs #(.W(REG_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_full),
        .rd_clr(rd_en && rd_addr),
        .irq   (irq)
    );

    always_comb begin
        status          = '0;
        status[BIT_LOS] = los_q;
        status[BIT_SEF] = sef;
        status[BIT_LOF] = lof;
        rd_data         = rd_addr ? irq : status;
    end

    assign int_n = ~|(irq & int_mask);

    // R3 / R6: every LOF change leaves its interrupt bit pending
    a_r3_lof_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lof) != lof) |-> irq[BIT_LOF]);
    // R2 / R5: every SEF change leaves its interrupt bit pending
    a_r2_sef_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sef) != sef) |-> irq[BIT_SEF]);
endmodule

// File: tb/fa_defect_monitor_test.sv
module fa_defect_monitor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_strobe = 1'b0;
    logic       frame_ok = 1'b0;
    logic       los_in = 1'b0;
    logic [3:0] frame_thr = 4'd3;
    logic [7:0] int_mask = 8'hFF;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       sef, lof, int_n;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // reference model: 0 = SEF/LOF, 1 = LOF only, 2 = in frame
    int m_state = 0;
    int m_good = 0;
    int m_bad = 0;
    bit m_los = 1'b0;
    bit [7:0] m_irq = 8'h00;

    always #10 clk = ~clk;

    fa_defect_monitor uut (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .frame_ok(frame_ok),
        .los_in(los_in), .frame_thr(frame_thr), .int_mask(int_mask), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .sef(sef), .lof(lof), .int_n(int_n)
    );

    always @(posedge clk) begin
        bit [7:0] ev;
        int need;
        ev = 8'h00;
        if (!rst_n) begin
            m_state = 0; m_good = 0; m_bad = 0; m_los = 1'b0; m_irq = 8'h00;
        end else begin
            if (los_in != m_los) begin m_los = los_in; ev[0] = 1'b1; end
            need = (frame_thr == 0) ? 1 : int'(frame_thr);
            if (frame_strobe) begin
                if (m_state == 0) begin
                    if (frame_ok) begin
                        m_good++;
                        if (m_good == 2) begin m_state = 1; m_good = 0; m_bad = 0; ev[1] = 1'b1; end
                    end else m_good = 0;
                end else if (m_state == 1) begin
                    if (frame_ok) begin
                        m_bad = 0; m_good++;
                        if (m_good >= need) begin m_state = 2; m_good = 0; ev[2] = 1'b1; end
                    end else begin
                        m_good = 0; m_bad++;
                        if (m_bad == 4) begin m_state = 0; m_bad = 0; ev[1] = 1'b1; end
                    end
                end else begin
                    if (frame_ok) m_bad = 0;
                    else begin
                        m_bad++;
                        if (m_bad == 4) begin m_state = 0; m_bad = 0; m_good = 0; ev[1] = 1'b1; ev[2] = 1'b1; end
                    end
                end
            end
            if (rd_en && rd_addr) m_irq = 8'h00;
            m_irq = m_irq | ev;
        end
    end

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #5;
        if (!done) begin
            chk("sef", {7'd0, sef}, {7'd0, m_state == 0});
            chk("lof", {7'd0, lof}, {7'd0, m_state != 2});
            chk("int_n", {7'd0, int_n}, {7'd0, (m_irq & int_mask) == 8'h00});
            if (rd_en)
                chk("rd_data", rd_data,
                    rd_addr ? m_irq : {5'd0, m_state != 2, m_state == 0, m_los});
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_strobe = 1'b0; rd_en = 1'b0;
        end
    endtask

    task automatic frame(input bit ok);
        @(negedge clk);
        frame_strobe = 1'b1; frame_ok = ok; rd_en = 1'b0;
        @(negedge clk);
        frame_strobe = 1'b0; frame_ok = ~ok;
        idle(1);
    endtask

    task automatic rd(input bit a);
        @(negedge clk);
        frame_strobe = 1'b0; rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        rd(1'b1); rd(1'b0);

        cur_req = "R2";
        frame(1); frame(0); frame(1); idle(2);
        frame(1); idle(2);
        rd(1'b1);

        cur_req = "R4";
        frame_thr = 4'd3;
        frame(1); frame(1); frame(0); frame(1); frame(1); idle(2);
        cur_req = "R3";
        frame(1); idle(2);
        cur_req = "R8";
        rd(1'b0); rd(1'b0);
        cur_req = "R9";
        rd(1'b1); rd(1'b1);

        cur_req = "R6";
        frame(0); frame(0); frame(0); frame(1);
        frame(0); frame(0); frame(0); frame(0); idle(2);
        rd(1'b1);

        cur_req = "R5";
        frame(1); frame(1);
        frame(0); frame(0); frame(0); frame(1);
        frame(0); frame(0); frame(0); frame(0); idle(2);
        rd(1'b1);

        cur_req = "R7";
        frame_thr = 4'd0;
        frame(1); frame(1); frame(1); idle(2);
        rd(1'b1);

        cur_req = "R12";
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); frame_ok = i[0];
        end
        idle(2);

        cur_req = "R11";
        los_in = 1'b1; idle(2);
        int_mask = 8'hFE; idle(2);
        int_mask = 8'h01; idle(2);
        int_mask = 8'hFF;
        rd(1'b0); rd(1'b1);

        cur_req = "R10";
        @(negedge clk);
        frame_strobe = 1'b1; frame_ok = 1'b0; los_in = 1'b0; rd_en = 1'b1; rd_addr = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0; rd_en = 1'b0;
        idle(2);
        rd(1'b1); rd(1'b1);

        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule